// File: doc/BRIEF.md
# Bus-master DMA register port

This block is the register front end of a two-channel bus-master DMA controller. It sits behind a 16-port I/O window: address bit 3 picks the channel and the three low address bits pick a register inside that channel's eight ports. Each channel has a command register, a status register and a 32-bit pointer to its descriptor table. Host software accesses these registers with byte or dword transfers, and every transfer gets a one-cycle response that carries the read data and an error flag for illegal accesses.

The data-moving engine connects through plain signals. For each channel, the block drives a run level, a direction level, a one-cycle start strobe and the table pointer. The engine drives three one-cycle event inputs back into the status register: transfer done, error and interrupt. The status register mixes three kinds of bits. Two bits are freely writable, two are write-one-to-clear flags set by hardware, and the active bit is read-only and owned by the start/stop logic and the engine.

Top module: `dma_ctl_regs`

## Requirements
- R1: Address bit 3 selects channel 0 or 1 and address bits 2:0 select the register: offset 0 command, offset 2 status, offsets 4..7 descriptor pointer bytes 0..3 (byte 0 least significant).
- R2: The access length code is 0 for byte, 1 for 16-bit and 2 for 32-bit. The legal accesses are: a byte at offsets 0, 1, 2, 3, 4, 5, 6 and 7, and a 32-bit access at offset 4 only. Any other access returns an error, reads back zero data and changes no state. A byte read at offset 1 or 3 returns zero without error, and a byte write there has no effect.
- R3: Every request gives exactly one response one cycle later. The response carries the read data zero-extended into the low bits (zero for writes) and the error flag.
- R4: Command bit 0 is the run bit and bit 3 is the direction bit, and both drive the run and direction outputs. The other command bits are ignored and read as zero.
- R5: A command write that takes the run bit from 0 to 1 sets status active (bit 0) and raises the start strobe for exactly one cycle. A write that takes it from 1 to 0 clears active. Writing 1 while the channel is already running produces no strobe.
- R6: A status write stores bits 5 and 6 from the written byte and leaves active (bit 0) unchanged.
- R7: In a status write, a 1 in bit 1 clears the error flag and a 1 in bit 2 clears the interrupt flag. A 0 in either bit leaves that flag as it was.
- R8: An engine done event clears active, an engine error event sets bit 1 and an engine interrupt event sets bit 2. A hardware set beats a same-cycle software clear, and a same-cycle start beats a done event.
- R9: Status bits 3, 4 and 7 always read as zero.
- R10: A byte write at offsets 4..7 replaces only that pointer byte. A 32-bit write at offset 4 replaces the whole pointer. A 32-bit read at offset 4 returns the whole pointer.
- R11: After reset, every register, strobe, output and response is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Port offset within the window |
| req_len | input | 2 | Access length code (0 byte, 1 16-bit, 2 32-bit) |
| req_wdata | input | 32 | Write data, low bits used for byte accesses |
| rsp_valid | output | 1 | Response valid, one cycle after a request |
| rsp_rdata | output | 32 | Read data, zero-extended |
| rsp_err | output | 1 | Access was illegal and had no effect |
| eng_done | input | 2 | Per-channel transfer finished event |
| eng_err | input | 2 | Per-channel error event |
| eng_irq | input | 2 | Per-channel interrupt event |
| run | output | 2 | Per-channel run level |
| dir | output | 2 | Per-channel direction level |
| start_pulse | output | 2 | Per-channel one-cycle start strobe |
| tbl_ptr | output | 64 | Descriptor pointers, channel 0 in bits 31:0 |

## Verification
The assertions watch, on every cycle, four things: the strobe lasts exactly one cycle and coincides with run and active, engine error and interrupt events always land, the error flag never drops unless it is written with a 1, and active is untouched by a status write. They also check that each request yields one response and that error responses carry zero data. The bench's scenarios are the only place where decode and byte-lane placement across both channels can be shown. The same holds for illegal-length rejection leaving state intact, the start-beats-done and set-beats-clear collisions, and read-back values after mixed sequences. All of these are compared against a behavioural model on every clock.

// File: rtl/dma_ctl_pkg.sv
// Package: shared types and bit positions for the DMA register port.
// Assumes a fixed 32-bit descriptor pointer and 8-bit command/status registers.
package dma_ctl_pkg;

    localparam int unsigned PTR_W    = 32;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned LANES    = PTR_W / 8;

    localparam int unsigned CMD_RUN  = 0;
    localparam int unsigned CMD_DIR  = 3;
    localparam int unsigned ST_ACT   = 0;
    localparam int unsigned ST_ERR   = 1;
    localparam int unsigned ST_IRQ   = 2;
    localparam int unsigned ST_SW_LO = 5;
    localparam int unsigned ST_SW_HI = 6;

    typedef enum logic [1:0] {
        LEN_BYTE = 2'd0,
        LEN_HALF = 2'd1,
        LEN_WORD = 2'd2,
        LEN_RSVD = 2'd3
    } acc_len_e;

    typedef struct packed {
        logic             legal;
        logic             cmd;
        logic             sts;
        logic             hole;
        logic [LANES-1:0] lanes;
    } acc_kind_t;

endpackage

// File: rtl/dma_ctl_decode.sv
// Module: splits a window offset into channel and register and checks the
// access length. Assumes CH_COUNT is a power of two and at least 2.
module dma_ctl_decode
    import dma_ctl_pkg::*;
#(
    parameter int CH_COUNT = 2,
    localparam int CH_W    = $clog2(CH_COUNT),
    localparam int AW      = 3 + CH_W
) (
    input  logic [AW-1:0]   addr,
    input  logic [1:0]      len,
    output logic [CH_W-1:0] ch,
    output acc_kind_t       kind
);

    logic [2:0] ofs;
    logic       is_byte;

    assign ofs     = addr[2:0];
    assign ch      = addr[AW-1:3];
    assign is_byte = (acc_len_e'(len) == LEN_BYTE);

    // Classify the access and decide whether its length is allowed.
    always_comb begin
        kind = '0;
        unique case (ofs)
            3'd0: begin
                kind.cmd   = is_byte;
                kind.legal = is_byte;
            end
            3'd2: begin
                kind.sts   = is_byte;
                kind.legal = is_byte;
            end
            3'd1, 3'd3: begin
                kind.hole  = is_byte;
                kind.legal = is_byte;
            end
            3'd4: begin
                if (is_byte) begin
                    kind.lanes = 4'b0001;
                    kind.legal = 1'b1;
                end else if (acc_len_e'(len) == LEN_WORD) begin
                    kind.lanes = 4'b1111;
                    kind.legal = 1'b1;
                end
            end
            default: begin
                if (is_byte) begin
                    kind.lanes = 4'b0001 << ofs[1:0];
                    kind.legal = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/dma_ctl_chan.sv
// Module: one channel's command, status and descriptor-pointer registers.
// Assumes write enables are already qualified by decode and legality.
module dma_ctl_chan
    import dma_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic             wr_sts,
    input  logic [LANES-1:0] wr_ptr,
    input  logic [PTR_W-1:0] wdata,
    input  logic             hw_done,
    input  logic             hw_err,
    input  logic             hw_irq,
    output logic             run,
    output logic             dir,
    output logic             start_pulse,
    output logic [REG_W-1:0] cmd_rb,
    output logic [REG_W-1:0] sts_rb,
    output logic [PTR_W-1:0] ptr
);

    logic act_q, err_q, irq_q, sw5_q, sw6_q;
    logic go_rise, go_fall;

    assign go_rise = wr_cmd &&  wdata[CMD_RUN] && !run;
    assign go_fall = wr_cmd && !wdata[CMD_RUN] &&  run;

    // Command bits and the one-cycle start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run         <= 1'b0;
            dir         <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= go_rise;
            if (wr_cmd) begin
                run <= wdata[CMD_RUN];
                dir <= wdata[CMD_DIR];
            end
        end
    end

    // Active bit: set on start, cleared on stop or engine done.
    always_ff @(posedge clk) begin
        if (!rst_n)                   act_q <= 1'b0;
        else if (go_rise)             act_q <= 1'b1;
        else if (go_fall || hw_done)  act_q <= 1'b0;
    end

    // Error and interrupt flags: hardware set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (hw_err)                        err_q <= 1'b1;
            else if (wr_sts && wdata[ST_ERR])  err_q <= 1'b0;
            if (hw_irq)                        irq_q <= 1'b1;
            else if (wr_sts && wdata[ST_IRQ])  irq_q <= 1'b0;
        end
    end

    // Plain software-owned status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw5_q <= 1'b0;
            sw6_q <= 1'b0;
        end else if (wr_sts) begin
            sw5_q <= wdata[ST_SW_LO];
            sw6_q <= wdata[ST_SW_HI];
        end
    end

    // Descriptor pointer, one register per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)         ptr[g*8 +: 8] <= '0;
            else if (wr_ptr[g]) ptr[g*8 +: 8] <= wdata[g*8 +: 8];
        end
    end

    assign cmd_rb = {4'b0, dir, 2'b0, run};
    assign sts_rb = {1'b0, sw6_q, sw5_q, 2'b0, irq_q, err_q, act_q};

    // Strobe never lasts more than one cycle.
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    // Strobe coincides with a running, active channel.
    p_pulse_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (run && act_q));
    // Engine error event always lands.
    p_hw_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_err |=> err_q);
    // Engine interrupt event always lands.
    p_hw_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_irq |=> irq_q);
    // Status writes cannot move the active bit.
    p_act_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && !wr_cmd && !hw_done) |=> $stable(act_q));
    // Error flag holds unless written with a one.
    p_w1c_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(wr_sts && wdata[ST_ERR])) |=> err_q);

endmodule

// File: rtl/dma_ctl_regs.sv
// Module: top of the DMA register port. Decodes requests, steers writes to
// the addressed channel, muxes read data and registers the response.
// Assumes one request per cycle and reads without side effects.
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int CH_COUNT = 2,
    localparam int CH_W    = $clog2(CH_COUNT),
    localparam int AW      = 3 + CH_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [AW-1:0]             req_addr,
    input  logic [1:0]                req_len,
    input  logic [PTR_W-1:0]          req_wdata,
    output logic                      rsp_valid,
    output logic [PTR_W-1:0]          rsp_rdata,
    output logic                      rsp_err,
    input  logic [CH_COUNT-1:0]       eng_done,
    input  logic [CH_COUNT-1:0]       eng_err,
    input  logic [CH_COUNT-1:0]       eng_irq,
    output logic [CH_COUNT-1:0]       run,
    output logic [CH_COUNT-1:0]       dir,
    output logic [CH_COUNT-1:0]       start_pulse,
    output logic [CH_COUNT*PTR_W-1:0] tbl_ptr
);

    logic [CH_W-1:0]  sel_ch;
    acc_kind_t        kind;
    logic             do_wr;
    logic [PTR_W-1:0] lane_data;
    logic [PTR_W-1:0] rd_mux;
    logic [REG_W-1:0] cmd_rb [CH_COUNT];
    logic [REG_W-1:0] sts_rb [CH_COUNT];
    logic [PTR_W-1:0] ptr_q  [CH_COUNT];

    dma_ctl_decode #(.CH_COUNT(CH_COUNT)) u_decode (
        .addr (req_addr),
        .len  (req_len),
        .ch   (sel_ch),
        .kind (kind)
    );

    assign do_wr     = req_valid && req_write && kind.legal;
    // Byte writes are replicated so each pointer lane sees its byte.
    assign lane_data = (kind.lanes == 4'b1111) ? req_wdata : {LANES{req_wdata[7:0]}};

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
        logic hit;
        assign hit = do_wr && (sel_ch == CH_W'(c));

        dma_ctl_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_cmd      (hit && kind.cmd),
            .wr_sts      (hit && kind.sts),
            .wr_ptr      (hit ? kind.lanes : '0),
            .wdata       (lane_data),
            .hw_done     (eng_done[c]),
            .hw_err      (eng_err[c]),
            .hw_irq      (eng_irq[c]),
            .run         (run[c]),
            .dir         (dir[c]),
            .start_pulse (start_pulse[c]),
            .cmd_rb      (cmd_rb[c]),
            .sts_rb      (sts_rb[c]),
            .ptr         (ptr_q[c])
        );

        assign tbl_ptr[c*PTR_W +: PTR_W] = ptr_q[c];
    end

    // Select read data for the addressed register.
    always_comb begin
        rd_mux = '0;
        if (kind.cmd)                 rd_mux = PTR_W'(cmd_rb[sel_ch]);
        else if (kind.sts)            rd_mux = PTR_W'(sts_rb[sel_ch]);
        else if (kind.lanes == 4'b1111) rd_mux = ptr_q[sel_ch];
        else if (|kind.lanes)         rd_mux = PTR_W'(ptr_q[sel_ch][req_addr[1:0]*8 +: 8]);
    end

    // Register the response one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !kind.legal;
            rsp_rdata <= (req_valid && !req_write && kind.legal) ? rd_mux : '0;
        end
    end

    // Each request is answered in the next cycle.
    p_rsp_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // No response without a request.
    p_rsp_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // An error response carries no data.
    p_err_nodata_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

endmodule

// File: tb/dma_ctl_regs_bench.sv
module dma_ctl_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [1:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [1:0]  eng_done = '0, eng_err = '0, eng_irq = '0;
    logic [1:0]  run, dir, start_pulse;
    logic [63:0] tbl_ptr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_ctl_regs u_dma_ctl_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .eng_done(eng_done), .eng_err(eng_err), .eng_irq(eng_irq),
        .run(run), .dir(dir), .start_pulse(start_pulse), .tbl_ptr(tbl_ptr)
    );

    // Behavioural reference state.
    bit          m_run[2], m_dir[2], m_act[2], m_err[2], m_irq[2], m_s5[2], m_s6[2], m_pulse[2];
    logic [31:0] m_ptr[2];
    bit          m_rv, m_re;
    logic [31:0] m_rd;

    function automatic bit legal_acc(int ofs, int len);
        if (len == 0) return 1;
        return (len == 2 && ofs == 4);
    endfunction

    function automatic logic [31:0] status_of(int c);
        return {25'b0, m_s6[c], m_s5[c], 2'b0, m_irq[c], m_err[c], m_act[c]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_run[c] = 0; m_dir[c] = 0; m_act[c] = 0; m_err[c] = 0;
                m_irq[c] = 0; m_s5[c] = 0; m_s6[c] = 0; m_pulse[c] = 0; m_ptr[c] = 0;
            end
            m_rv = 0; m_re = 0; m_rd = 0;
        end else begin
            int  c, ofs, len;
            bit  started[2];
            c = req_addr[3]; ofs = req_addr[2:0]; len = req_len;
            started[0] = 0; started[1] = 0;
            m_pulse[0] = 0; m_pulse[1] = 0;
            m_rv = req_valid; m_re = 0; m_rd = 0;
            if (req_valid) begin
                if (!legal_acc(ofs, len)) m_re = 1;
                else if (!req_write) begin
                    if (ofs == 0) m_rd = {28'b0, m_dir[c], 2'b0, m_run[c]};
                    else if (ofs == 2) m_rd = status_of(c);
                    else if (ofs >= 4 && len == 2) m_rd = m_ptr[c];
                    else if (ofs >= 4) m_rd = (m_ptr[c] >> (8 * (ofs - 4))) & 32'hFF;
                end else begin
                    if (ofs == 0) begin
                        if (req_wdata[0] && !m_run[c]) begin
                            m_act[c] = 1; m_pulse[c] = 1; started[c] = 1;
                        end else if (!req_wdata[0] && m_run[c]) m_act[c] = 0;
                        m_run[c] = req_wdata[0]; m_dir[c] = req_wdata[3];
                    end else if (ofs == 2) begin
                        m_s5[c] = req_wdata[5]; m_s6[c] = req_wdata[6];
                        if (req_wdata[1]) m_err[c] = 0;
                        if (req_wdata[2]) m_irq[c] = 0;
                    end else if (ofs >= 4 && len == 2) m_ptr[c] = req_wdata;
                    else if (ofs >= 4) m_ptr[c][8*(ofs-4) +: 8] = req_wdata[7:0];
                end
            end
            for (int k = 0; k < 2; k++) begin
                if (eng_done[k] && !started[k]) m_act[k] = 0;
                if (eng_err[k]) m_err[k] = 1;
                if (eng_irq[k]) m_irq[k] = 1;
            end
        end
    end

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare outputs with the reference on every falling edge.
    always @(negedge clk) begin
        if (!finished) begin
            check(rsp_valid == m_rv && rsp_err == m_re && rsp_rdata == m_rd, "R3 response",
                  {rsp_valid, rsp_err, rsp_rdata}, {m_rv, m_re, m_rd});
            check(run == {m_run[1], m_run[0]} && dir == {m_dir[1], m_dir[0]}, "R4 run/dir",
                  {run, dir}, {m_run[1], m_run[0], m_dir[1], m_dir[0]});
            check(start_pulse == {m_pulse[1], m_pulse[0]}, "R5 strobe",
                  start_pulse, {m_pulse[1], m_pulse[0]});
            check(tbl_ptr == {m_ptr[1], m_ptr[0]}, "R10 pointer", tbl_ptr, {m_ptr[1], m_ptr[0]});
        end
    end

    task automatic acc(input bit wr, input logic [3:0] a, input logic [1:0] l,
                       input logic [31:0] d, output logic [31:0] rd, output logic er);
        req_valid = 1; req_write = wr; req_addr = a; req_len = l; req_wdata = d;
        @(negedge clk);
        rd = rsp_rdata; er = rsp_err;
        req_valid = 0; req_write = 0; eng_done = 0; eng_err = 0; eng_irq = 0;
    endtask

    task automatic idle();
        @(negedge clk);
        eng_done = 0; eng_err = 0; eng_irq = 0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic er;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        check(run == 0 && start_pulse == 0 && tbl_ptr == 0 && rsp_valid == 0, "R11 reset", {run, tbl_ptr[31:0]}, 0);
        acc(0, 4'h2, 0, 0, rd, er);
        check(rd == 0 && !er, "R11 status zero", rd, 0);

        // R1/R10: pointer on channel 1 only
        acc(1, 4'hC, 2, 32'hDEADBEEF, rd, er);
        acc(0, 4'hC, 2, 0, rd, er);
        check(rd == 32'hDEADBEEF, "R10 dword readback", rd, 32'hDEADBEEF);
        acc(0, 4'h4, 2, 0, rd, er);
        check(rd == 0, "R1 channel isolation", rd, 0);
        acc(1, 4'hE, 0, 32'h0000005A, rd, er);
        acc(0, 4'hC, 2, 0, rd, er);
        check(rd == 32'hDE5ABEEF, "R10 byte lane write", rd, 32'hDE5ABEEF);
        acc(0, 4'hF, 0, 0, rd, er);
        check(rd == 32'hDE, "R1 byte offset 7", rd, 32'hDE);

        // R2: illegal lengths rejected without effect
        acc(1, 4'hD, 2, 32'h11111111, rd, er);
        check(er == 1, "R2 dword at offset 5", er, 1);
        acc(1, 4'hA, 1, 32'hFF, rd, er);
        check(er == 1, "R2 half status", er, 1);
        acc(1, 4'h0, 2, 32'h1, rd, er);
        check(er == 1 && run == 0, "R2 dword command", {er, run}, 4);
        acc(0, 4'h0, 3, 0, rd, er);
        check(er == 1 && rd == 0, "R2 reserved length", {er, rd}, 64'h100000000);
        acc(1, 4'h1, 0, 32'hFF, rd, er);
        acc(0, 4'h1, 0, 0, rd, er);
        check(er == 0 && rd == 0, "R2 hole offset", {er, rd}, 0);
        acc(0, 4'hC, 2, 0, rd, er);
        check(rd == 32'hDE5ABEEF, "R2 pointer untouched", rd, 32'hDE5ABEEF);

        // R4/R5: start channel 0
        acc(1, 4'h0, 0, 32'hFF, rd, er);
        check(start_pulse == 2'b01 && run == 2'b01 && dir == 2'b01, "R5 start strobe", {start_pulse, run, dir}, 6'b010101);
        acc(0, 4'h0, 0, 0, rd, er);
        check(rd == 32'h09, "R4 command readback", rd, 32'h09);
        check(start_pulse == 0, "R5 strobe one cycle", start_pulse, 0);
        acc(1, 4'h0, 0, 32'h01, rd, er);
        check(start_pulse == 0 && dir == 0, "R5 no restrobe", {start_pulse, dir}, 0);

        // R6/R9: status write keeps active
        acc(1, 4'h2, 0, 32'hFF, rd, er);
        acc(0, 4'h2, 0, 0, rd, er);
        check(rd == 32'h61, "R6 R9 status write", rd, 32'h61);

        // R8/R7: hardware sets and write-one-to-clear
        eng_err = 2'b01; eng_irq = 2'b01;
        idle();
        acc(0, 4'h2, 0, 0, rd, er);
        check(rd == 32'h67, "R8 hw set", rd, 32'h67);
        acc(1, 4'h2, 0, 32'h62, rd, er);
        acc(0, 4'h2, 0, 0, rd, er);
        check(rd == 32'h65, "R7 clear error only", rd, 32'h65);
        eng_irq = 2'b01;
        acc(1, 4'h2, 0, 32'h64, rd, er);
        acc(0, 4'h2, 0, 0, rd, er);
        check(rd == 32'h65, "R8 set beats clear", rd, 32'h65);
        acc(1, 4'h2, 0, 32'h04, rd, er);
        acc(0, 4'h2, 0, 0, rd, er);
        check(rd == 32'h01, "R7 clear irq", rd, 32'h01);

        // R8: engine done clears active
        eng_done = 2'b01;
        idle();
        acc(0, 4'h2, 0, 0, rd, er);
        check(rd == 32'h00 && run[0] == 1, "R8 done clears active", rd, 0);

        // R5/R8: stop, then start colliding with done
        acc(1, 4'h0, 0, 32'h00, rd, er);
        eng_done = 2'b01;
        acc(1, 4'h0, 0, 32'h01, rd, er);
        check(start_pulse == 2'b01, "R5 restart strobe", start_pulse, 1);
        acc(0, 4'h2, 0, 0, rd, er);
        check(rd == 32'h01, "R8 start beats done", rd, 1);
        acc(1, 4'h0, 0, 32'h00, rd, er);
        acc(0, 4'h2, 0, 0, rd, er);
        check(rd == 32'h00, "R5 stop clears active", rd, 0);

        // R1: channel 1 status independent of channel 0
        acc(1, 4'h8, 0, 32'h01, rd, er);
        acc(0, 4'hA, 0, 0, rd, er);
        check(rd == 32'h01, "R1 channel 1 active", rd, 1);
        acc(0, 4'h2, 0, 0, rd, er);
        check(rd == 32'h00, "R1 channel 0 untouched", rd, 0);

        repeat (2) idle();
        finish_run();
    end

endmodule